// File: doc/BRIEF.md
# SPI Transmit Byte Queue with Depth-Revealing Watermark

This block is the transmit side of an SPI controller. Software writes bytes through a data-write address on a simple register bus. The block stores them in a power-of-two ring buffer, and the serial shift engine pulls them out one at a time. The engine sees the head byte before it pops it. The block tracks how many bytes are held and raises a full flag and a below-watermark flag. Interrupt logic elsewhere can use these flags to ask software for more data.

The watermark register holds only as many bits as an index into the buffer. A write keeps the low bits and drops the rest. Software can therefore write all ones and read back the buffer depth minus one, and so learn the depth without any extra identification register. Driving the enable input low empties the queue.

Top module: `spi_txq`

## Requirements
- R1: After reset the queue is empty, the level is 0, the full flag is low, and the watermark reads back as 1.
- R2: A bus write to address 0x1C while enabled appends `bus_wdata[7:0]`. Bytes leave through `eng_data`/`eng_pop` in the order they were written. `eng_data` shows the oldest byte before it is popped.
- R3: A bus write to address 0x28 loads the watermark with the low log2(DEPTH) bits of `bus_wdata`. Reading address 0x28 returns that value zero-extended, so writing 0xFFFF reads back as DEPTH-1.
- R4: `tx_below_wm` is high exactly when the level is strictly less than the watermark value.
- R5: `tx_full` is high exactly when the level equals DEPTH.
- R6: A data write while the queue is full is dropped. The level stays at DEPTH and the stored bytes come out unchanged.
- R7: A pop while the queue is empty is ignored, and the level stays 0.
- R8: A push and a pop accepted in the same cycle leave the level unchanged and keep the byte order.
- R9: While `enable` is low the queue is flushed to empty and data writes are dropped. Bytes written after re-enabling come out first.
- R10: Bus writes to any address other than 0x1C do not change the queue contents or level. Reads of any address other than 0x28 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Controller enable; low flushes the queue |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data (watermark at 0x28) |
| eng_pop | input | 1 | Shift engine takes the head byte |
| eng_data | output | 8 | Head byte of the queue |
| tx_empty | output | 1 | Queue holds no bytes |
| tx_full | output | 1 | Queue holds DEPTH bytes |
| tx_below_wm | output | 1 | Level is below the watermark |
| tx_level | output | log2(DEPTH)+1 | Number of bytes held |

## Verification
The bench fills the queue to exactly DEPTH and writes one more byte. A design that accepted the extra byte would overwrite the oldest entry and deliver the wrong byte first. It pushes and pops in the same cycle with bytes already queued; a design that gave one side priority would drift the level by one. The watermark probe with all ones catches a register that is wider or narrower than the index, which would read back a wrong depth. The bench also pops an empty queue and writes during a flush. A design that moved a pointer in either case would later hand the engine stale bytes.

// File: rtl/spi_txq_pkg.sv
package spi_txq_pkg;
  localparam logic [7:0] ADDR_TXDATA = 8'h1C;
  localparam logic [7:0] ADDR_WMARK  = 8'h28;
  localparam int unsigned WM_RESET   = 1;

  // occupancy arithmetic: one in, one out, both, or neither
  function automatic int unsigned next_level(input int unsigned cur,
                                             input logic up, input logic dn);
    case ({up, dn})
      2'b10:   return cur + 1;
      2'b01:   return cur - 1;
      default: return cur;
    endcase
  endfunction
endpackage

// File: rtl/spi_txq_store.sv
module spi_txq_store #(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push_ok,
  input  logic          pop_ok,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata,
  output logic [AW-1:0] wr_ptr,
  output logic [AW-1:0] rd_ptr
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (push_ok) wr_ptr <= wr_ptr + 1'b1;
      if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
    end
  end

  assign rdata = mem[rd_ptr];

  // R9: flush returns both pointers home
  p_flush_ptrs_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (wr_ptr == '0 && rd_ptr == '0));
endmodule

// File: rtl/spi_txq_count.sv
module spi_txq_count
  import spi_txq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int LW = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push_req,
  input  logic          pop_req,
  output logic          push_ok,
  output logic          pop_ok,
  output logic          full,
  output logic          empty,
  output logic [LW-1:0] level
);
  assign full    = (level == LW'(DEPTH));
  assign empty   = (level == '0);
  assign push_ok = push_req && !full && !flush;
  assign pop_ok  = pop_req && !empty && !flush;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     level <= '0;
    else if (flush) level <= '0;
    else            level <= LW'(next_level(int'(level), push_ok, pop_ok));
  end

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push_req && !pop_req) |=> full);
  p_pop_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop_req && !push_req) |=> empty);
  p_both_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ok && pop_ok) |=> $stable(level));
  p_flush_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (level == '0));
endmodule

// File: rtl/spi_txq_wmark.sv
module spi_txq_wmark
  import spi_txq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [31:0]   wdata,
  output logic [AW-1:0] wm
);
  // keep only the bits an index needs; the rest is discarded
  function automatic logic [AW-1:0] trunc(input logic [31:0] d);
    return d[AW-1:0];
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  wm <= AW'(WM_RESET);
    else if (we) wm <= trunc(wdata);
  end

  p_wm_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(wm));
endmodule

// File: rtl/spi_txq.sv
module spi_txq
  import spi_txq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          bus_we,
  input  logic [7:0]    bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  input  logic          eng_pop,
  output logic [7:0]    eng_data,
  output logic          tx_empty,
  output logic          tx_full,
  output logic          tx_below_wm,
  output logic [LW-1:0] tx_level
);
  // named internal events
  logic          flush, push_req, push_ok, pop_ok, wm_we;
  logic [AW-1:0] wr_ptr, rd_ptr, wm;

  assign flush    = !enable;
  assign push_req = bus_we && (bus_addr == ADDR_TXDATA);
  assign wm_we    = bus_we && (bus_addr == ADDR_WMARK);

  spi_txq_count #(.DEPTH(DEPTH)) u_count (
    .clk(clk), .rst_n(rst_n), .flush(flush), .push_req(push_req),
    .pop_req(eng_pop), .push_ok(push_ok), .pop_ok(pop_ok),
    .full(tx_full), .empty(tx_empty), .level(tx_level));

  spi_txq_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .flush(flush), .push_ok(push_ok),
    .pop_ok(pop_ok), .wdata(bus_wdata[7:0]), .rdata(eng_data),
    .wr_ptr(wr_ptr), .rd_ptr(rd_ptr));

  spi_txq_wmark #(.DEPTH(DEPTH)) u_wmark (
    .clk(clk), .rst_n(rst_n), .we(wm_we), .wdata(bus_wdata), .wm(wm));

  assign tx_below_wm = tx_level < {1'b0, wm};
  assign bus_rdata   = (bus_addr == ADDR_WMARK) ? 32'(wm) : 32'd0;

  // R2: pointers coincide whenever the counter says empty
  p_empty_ptrs_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |-> (wr_ptr == rd_ptr));
  // R6: a rejected write does not move the write pointer
  p_full_ptr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_full && push_req) |=> $stable(wr_ptr));
  // R10: other addresses never advance the write pointer
  p_other_addr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!push_req && enable) |=> $stable(wr_ptr));
endmodule

// File: tb/spi_txq_test.sv
`timescale 1ns/1ps
module spi_txq_test;
  localparam int DEPTH = 16;
  localparam int LW = $clog2(DEPTH) + 1;

  logic clk = 0, rst_n = 0, enable = 0, bus_we = 0, eng_pop = 0;
  logic [7:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic [7:0] eng_data;
  logic tx_empty, tx_full, tx_below_wm;
  logic [LW-1:0] tx_level;

  int tests = 0, fails = 0;
  byte unsigned exp_q[$];
  int unsigned wm_model = 1;

  always #5 clk = ~clk;

  spi_txq #(.DEPTH(DEPTH)) uut (.*);

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    bus_we = 1; bus_addr = a; bus_wdata = d;
    if (a == 8'h1C && enable && exp_q.size() < DEPTH) exp_q.push_back(d[7:0]);
    tick();
    bus_we = 0;
  endtask

  task automatic wm_read(output int v);
    bus_addr = 8'h28; #1; v = bus_rdata;
  endtask

  // monitor: compare the head byte against the scoreboard, then take it
  task automatic pop_check(input string req);
    if (exp_q.size() > 0) begin
      chk(req, eng_data, exp_q[0]);
      void'(exp_q.pop_front());
    end
    eng_pop = 1; tick(); eng_pop = 0;
  endtask

  task automatic flags_check(input string tag);
    chk({tag, " R5 full"}, tx_full, exp_q.size() == DEPTH);
    chk({tag, " R4 below"}, tx_below_wm, exp_q.size() < wm_model);
    chk({tag, " level"}, tx_level, exp_q.size());
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int v;
    #1; tick(); tick();
    // R1 reset state
    chk("R1 empty", tx_empty, 1);
    chk("R1 level", tx_level, 0);
    chk("R1 full", tx_full, 0);
    wm_read(v); chk("R1 wm reset", v, 1);
    chk("R4 below at reset", tx_below_wm, 1);
    rst_n = 1; enable = 1; tick();

    // R3 depth discovery
    bus_write(8'h28, 32'h0000_FFFF);
    wm_read(v); chk("R3 wm probe", v, DEPTH - 1);
    bus_write(8'h28, 32'h0000_0014); wm_model = 4;
    wm_read(v); chk("R3 wm trunc", v, 4);
    bus_addr = 8'h24; #1; chk("R10 read other", bus_rdata, 0);

    // R2 / R4 ordering and watermark crossing
    bus_write(8'h1C, 32'hA1); bus_write(8'h1C, 32'hB2); bus_write(8'h1C, 32'hC3);
    flags_check("three");
    bus_write(8'h1C, 32'hD4);
    flags_check("four");
    for (int i = 0; i < 4; i++) pop_check("R2 order");
    chk("R2 drained", tx_empty, 1);

    // R7 pop on empty
    pop_check("R7"); chk("R7 level", tx_level, 0);

    // R10 writes elsewhere
    bus_write(8'h20, 32'h55); bus_write(8'h24, 32'h66);
    chk("R10 level", tx_level, 0);

    // R5 / R6 fill and overflow
    for (int i = 0; i < DEPTH; i++) bus_write(8'h1C, 32'(8'h30 + i));
    flags_check("filled");
    bus_write(8'h1C, 32'hEE);
    chk("R6 level", tx_level, DEPTH);
    for (int i = 0; i < DEPTH; i++) pop_check("R6 contents");
    chk("R6 empty", tx_empty, 1);

    // R8 simultaneous push and pop
    bus_write(8'h1C, 32'h71); bus_write(8'h1C, 32'h72);
    chk("R8 byte", eng_data, exp_q[0]);
    void'(exp_q.pop_front()); exp_q.push_back(8'h73);
    bus_we = 1; bus_addr = 8'h1C; bus_wdata = 32'h73; eng_pop = 1;
    tick(); bus_we = 0; eng_pop = 0;
    chk("R8 level", tx_level, 2);
    pop_check("R8 order"); pop_check("R8 order");

    // R9 flush on disable
    bus_write(8'h1C, 32'h91); bus_write(8'h1C, 32'h92); bus_write(8'h1C, 32'h93);
    enable = 0; tick(); exp_q.delete();
    chk("R9 flushed", tx_level, 0);
    bus_write(8'h1C, 32'h94);
    chk("R9 dropped", tx_level, 0);
    enable = 1; tick();
    bus_write(8'h1C, 32'hA5);
    chk("R9 level", tx_level, 1);
    pop_check("R9 fresh");
    chk("R9 empty", tx_empty, 1);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule